// File: doc/BRIEF.md
# Port Width Adapter with Upper-Lane Steering

This block sits between a 32-bit internal data path and an external 32-bit data bus that serves several memory banks. Each bank has a port width of 8, 16 or 32 bits, and a narrow port occupies only the most significant external byte lanes. For every request the adapter looks up the width of the addressed bank and places the internal bytes on the external lanes that port actually wires up. When the access is wider than the port, it breaks the access into consecutive bus cycles and rebuilds the read data into one internal word.

Inside the adapter, data is byte-lane aligned and big-endian: the byte at address offset k within a 32-bit word sits at internal bits [31-8k -: 8]. Each bus cycle opens with a one-cycle start pulse. Address, direction and write data then stay steady until the external side returns done. A completion pulse comes back once the last bus cycle of the access has finished.

Top module: `bus_sizer`

## Requirements
- R1: Bank b takes its port-width code from bank_psize_i[2b+1:2b]. Code 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. The request size code works the same way: 00 is a byte, 01 a halfword, and 10 or 11 a word.
- R2: A 32-bit port needs one bus cycle for any access. Each internal byte travels on its own lane, so offset k maps to external bits [31-8k -: 8].
- R3: A word access to a 16-bit port takes two bus cycles, at the word address and then at that address plus 2. The lower address goes first. Each cycle carries its two bytes on external bits 31:16.
- R4: A word access to an 8-bit port takes four bus cycles, at the base address plus 0, 1, 2 and 3 in that order. Each byte travels on external bits 31:24.
- R5: A halfword access to an 8-bit port takes two bus cycles, at the base address and the base address plus 1. An access no wider than its port takes a single bus cycle.
- R6: On a read, the bytes of each bus cycle come from the port's own lanes, and external lane (k mod port bytes) fills internal byte k. Internal bytes outside the access return as zero. rsp_valid_o pulses for one cycle, in the cycle right after done is returned for the last bus cycle.
- R7: On a write, every active lane of the port carries a copy of the bytes of the current bus cycle. Lanes outside the port are driven to zero. When no bus cycle is in progress, bus_wdata_o is zero and bus_we_o is low.
- R8: bus_start_o is a single-cycle pulse. It comes in the cycle after a request is accepted, or in the cycle after done for a bus cycle that is not the last one. bus_addr_o, bus_we_o and bus_wdata_o stay unchanged from the start pulse until done.
- R9: req_ready_o is low from acceptance until the last done. A request held valid during that time is not taken, and a done that arrives while no bus cycle is waiting has no effect.
- R10: The request address is rounded down to a multiple of the access size before it is used.
- R11: After reset, req_ready_o is high and both bus_start_o and rsp_valid_o are low.
- R12: A write completes with a rsp_valid_o pulse and rsp_rdata_o equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_psize_i | input | 2*N_BANKS | Port-width code for each bank |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Adapter idle, request can be taken |
| req_bank_i | input | BANK_W | Bank being addressed |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code |
| req_we_i | input | 1 | Write when high |
| req_wdata_i | input | 32 | Write data, lane-aligned big-endian |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | 32 | Reassembled read data |
| bus_start_o | output | 1 | Bus cycle start pulse |
| bus_addr_o | output | ADDR_W | Byte address of the current bus cycle |
| bus_we_o | output | 1 | Current bus cycle is a write |
| bus_wdata_o | output | 32 | Steered write data |
| bus_rdata_i | input | 32 | External read data, taken together with done |
| bus_done_i | input | 1 | Current bus cycle finished |

## Verification
The first start pulse is due exactly one cycle after the edge that accepts the request. Every later start pulse, and the completion pulse, is due exactly one cycle after the cycle in which the bench drives done. The bus model records those cycle numbers and compares them with the cycle in which each pulse actually appears. The bench changes inputs and samples outputs on the falling edge, and done is held off for one to three cycles so that latency does not hide a sequencing error.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } bsz_state_e;

  // log2 of byte count; code 3 folds onto 32 bits
  function automatic logic [1:0] lg_bytes(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction

  typedef struct packed {
    logic              we;
    logic [1:0]        lpt;   // log2 port bytes
    logic [1:0]        lw;    // log2 bytes per bus cycle
    logic [1:0]        last;  // index of final bus cycle
    logic [DATA_W-1:0] wdata;
  } xfer_t;
endpackage

// File: rtl/bsz_beat_plan.sv
module bsz_beat_plan
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        psize_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [1:0]        lpt_o,
  output logic [1:0]        lw_o,
  output logic [1:0]        last_o
);
  logic [1:0] lsz;
  logic [1:0] diff;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    lsz    = lg_bytes(size_i);
    lpt_o  = lg_bytes(psize_i);
    lw_o   = (lsz < lpt_o) ? lsz : lpt_o;
    diff   = (lsz > lpt_o) ? (lsz - lpt_o) : 2'd0;
    last_o = 2'((3'd1 << diff) - 3'd1);
    mask   = (ADDR_W'(1) << lsz) - ADDR_W'(1);
    base_o = addr_i & ~mask;
  end
endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        lw_i,
  input  logic [1:0]        lpt_i,
  output logic [DATA_W-1:0] ext_o
);
  logic [LANE_W-1:0] wb [LANES];
  logic [1:0] wmask;
  logic [1:0] pmask;

  assign wmask = 2'((3'd1 << lw_i) - 3'd1);
  assign pmask = 2'((3'd1 << lpt_i) - 3'd1);

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign wb[k] = wdata_i[DATA_W-1-LANE_W*k -: LANE_W];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] idx;
    assign idx = off_i + (2'(j) & wmask);
    assign ext_o[DATA_W-1-LANE_W*j -: LANE_W] =
      (2'(j) <= pmask) ? wb[idx] : '0;
  end
endmodule

// File: rtl/bsz_rd_merge.sv
module bsz_rd_merge
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        lw_i,
  input  logic [1:0]        lpt_i,
  output logic [DATA_W-1:0] acc_o
);
  logic [LANE_W-1:0] eb [LANES];
  logic [2:0] lo;
  logic [2:0] hi;
  logic [1:0] pmask;

  assign lo    = {1'b0, off_i};
  assign hi    = lo + (3'd1 << lw_i);
  assign pmask = 2'((3'd1 << lpt_i) - 3'd1);

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign eb[l] = ext_i[DATA_W-1-LANE_W*l -: LANE_W];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic       hit;
    logic [1:0] lane;
    assign hit  = (3'(k) >= lo) && (3'(k) < hi);
    assign lane = 2'(k) & pmask;
    assign acc_o[DATA_W-1-LANE_W*k -: LANE_W] =
      hit ? eb[lane] : acc_i[DATA_W-1-LANE_W*k -: LANE_W];
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int  ADDR_W  = 32,
  parameter int  N_BANKS = 4,
  localparam int BANK_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_BANKS-1:0] bank_psize_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic                 req_we_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic                 bus_start_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic                 bus_we_o,
  output logic [DATA_W-1:0]    bus_wdata_o,
  input  logic [DATA_W-1:0]    bus_rdata_i,
  input  logic                 bus_done_i
);
  bsz_state_e        state_q;
  xfer_t             xf_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [DATA_W-1:0] acc_q;
  logic              rsp_q;

  logic [1:0]        psel;
  logic [ADDR_W-1:0] base_d;
  logic [1:0]        lpt_d, lw_d, last_d;
  logic [ADDR_W-1:0] beat_addr;
  logic [DATA_W-1:0] steered;
  logic [DATA_W-1:0] merged;
  logic              busy;

  assign psel = bank_psize_i[{req_bank_i, 1'b0} +: 2];

  bsz_beat_plan #(.ADDR_W(ADDR_W)) u_plan (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .psize_i (psel),
    .base_o  (base_d),
    .lpt_o   (lpt_d),
    .lw_o    (lw_d),
    .last_o  (last_d)
  );

  assign beat_addr = base_q + (ADDR_W'(beat_q) << xf_q.lpt);

  bsz_wr_steer u_wr (
    .wdata_i (xf_q.wdata),
    .off_i   (beat_addr[1:0]),
    .lw_i    (xf_q.lw),
    .lpt_i   (xf_q.lpt),
    .ext_o   (steered)
  );

  bsz_rd_merge u_rd (
    .ext_i   (bus_rdata_i),
    .acc_i   (acc_q),
    .off_i   (beat_addr[1:0]),
    .lw_i    (xf_q.lw),
    .lpt_i   (xf_q.lpt),
    .acc_o   (merged)
  );

  assign busy        = (state_q != ST_IDLE);
  assign req_ready_o = !busy;
  assign bus_start_o = (state_q == ST_START);
  assign bus_addr_o  = beat_addr;
  assign bus_we_o    = busy && xf_q.we;
  assign bus_wdata_o = (busy && xf_q.we) ? steered : '0;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      xf_q    <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      acc_q   <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          xf_q.we    <= req_we_i;
          xf_q.lpt   <= lpt_d;
          xf_q.lw    <= lw_d;
          xf_q.last  <= last_d;
          xf_q.wdata <= req_wdata_i;
          base_q     <= base_d;
          beat_q     <= '0;
          acc_q      <= '0;
          state_q    <= ST_START;
        end
        ST_START: state_q <= ST_WAIT;
        ST_WAIT: if (bus_done_i) begin
          if (!xf_q.we) acc_q <= merged;
          if (beat_q == xf_q.last) begin
            state_q <= ST_IDLE;
            rsp_q   <= 1'b1;
          end else begin
            beat_q  <= beat_q + 2'd1;
            state_q <= ST_START;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              bus_start_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_we_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_done_i
);
  assert_start_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> bus_start_o);

  assert_start_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |=> !bus_start_o);

  assert_beat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |=> ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o)));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_o |-> !req_ready_o);

  assert_rsp_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(bus_done_i));

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bus_wdata_o == 32'h0 && !bus_we_o));
endmodule

bind bus_sizer bus_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .bus_start_o (bus_start_o),
  .bus_addr_o  (bus_addr_o),
  .bus_we_o    (bus_we_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_done_i  (bus_done_i)
);

// File: tb/sim_bus_sizer.sv
module sim_bus_sizer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bank_psize;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_start;
  logic [31:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 32'hDEADBEEF;
  logic        bus_done = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int next_start_cyc = 0;
  int exp_rsp_cyc = 0;
  int beat_no = 0;

  // expected bus cycles
  logic [31:0] qb_addr[$];
  logic        qb_we[$];
  logic [31:0] qb_data[$];
  logic        qb_last[$];
  int          qb_pb[$];
  string       qb_tag[$];
  // expected completions
  logic [31:0] qr_data[$];
  string       qr_tag[$];

  // bank0 8-bit, bank1 16-bit, bank2 32-bit (10), bank3 32-bit (11)
  assign bank_psize = {2'b11, 2'b10, 2'b01, 2'b00};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_sizer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bank_psize_i(bank_psize),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_we_i(req_we),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_start_o(bus_start), .bus_addr_o(bus_addr), .bus_we_o(bus_we),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_done_i(bus_done)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'h31;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int bank, input logic [1:0] sz, input logic [31:0] addr,
                        input logic we, input logic [31:0] wd, input string tag);
    int pcode, lpt, lsz, sb, pb, n, w, o;
    logic [31:0] base, ba, d, r;
    pcode = (bank == 0) ? 0 : (bank == 1) ? 1 : (bank == 2) ? 2 : 3;
    lpt = (pcode == 3) ? 2 : pcode;
    lsz = (sz == 2'b11) ? 2 : int'(sz);
    sb = 1 << lsz;
    pb = 1 << lpt;
    base = addr & ~(32'(sb) - 32'd1);
    n = (sb > pb) ? sb / pb : 1;
    w = (sb < pb) ? sb : pb;
    for (int i = 0; i < n; i++) begin
      ba = base + 32'(i * pb);
      o = int'(ba[1:0]);
      d = '0;
      if (we)
        for (int j = 0; j < pb; j++)
          d[31-8*j -: 8] = wd[31-8*(o + (j % w)) -: 8];
      qb_addr.push_back(ba); qb_we.push_back(we); qb_data.push_back(d);
      qb_last.push_back(i == n - 1); qb_pb.push_back(pb); qb_tag.push_back(tag);
    end
    r = '0;
    if (!we)
      for (int k = 0; k < 4; k++)
        if (k >= int'(base[1:0]) && k < int'(base[1:0]) + sb)
          r[31-8*k -: 8] = pat({base[31:2], 2'b00} + 32'(k));
    qr_data.push_back(r); qr_tag.push_back(tag);
    req_bank = 2'(bank); req_size = sz; req_addr = addr; req_we = we; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    next_start_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // bus model: checks each bus cycle, answers after 1..3 cycles
  task automatic responder();
    forever begin
      if (rst_ni && bus_start) begin
        int dly;
        logic [31:0] rd;
        if (qb_addr.size() == 0) begin
          chk(1'b0, "R9 unexpected bus cycle", bus_addr, 32'h0);
          @(negedge clk);
        end else begin
          logic [31:0] ea, ed; logic ew, el; int pb; string tg;
          ea = qb_addr.pop_front(); ew = qb_we.pop_front(); ed = qb_data.pop_front();
          el = qb_last.pop_front(); pb = qb_pb.pop_front(); tg = qb_tag.pop_front();
          chk(bus_addr == ea, {tg, " addr"}, bus_addr, ea);
          chk(bus_we == ew, {tg, " we"}, 32'(bus_we), 32'(ew));
          chk(bus_wdata == ed, {tg, " wdata"}, bus_wdata, ed);
          chk(cyc == next_start_cyc, "R8 start latency", 32'(cyc), 32'(next_start_cyc));
          rd = 32'hEEEEEEEE;
          for (int j = 0; j < pb; j++)
            rd[31-8*j -: 8] = pat((ea & ~(32'(pb) - 32'd1)) + 32'(j));
          dly = (beat_no % 3) + 1;
          beat_no++;
          repeat (dly) @(negedge clk);
          bus_done = 1'b1;
          bus_rdata = rd;
          if (el) exp_rsp_cyc = cyc + 1;
          else    next_start_cyc = cyc + 1;
          @(negedge clk);
          bus_done = 1'b0;
          bus_rdata = 32'hDEADBEEF;
        end
      end else begin
        @(negedge clk);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && rsp_valid) begin
      if (qr_data.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] er; string tg;
        er = qr_data.pop_front(); tg = qr_tag.pop_front();
        chk(rsp_rdata == er, {tg, " rdata"}, rsp_rdata, er);
        chk(cyc == exp_rsp_cyc, "R6 completion latency", 32'(cyc), 32'(exp_rsp_cyc));
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'h1);
    chk(bus_start == 1'b0, "R11 start after reset", 32'(bus_start), 32'h0);
    chk(rsp_valid == 1'b0, "R11 rsp after reset", 32'(rsp_valid), 32'h0);
    chk(bus_wdata == 32'h0, "R7 idle wdata", bus_wdata, 32'h0);
    fork responder(); join_none

    // R2 32-bit port
    do_req(2, 2'b10, 32'h0000_0100, 1'b1, 32'h1122_3344, "R2 word write p32");
    do_req(2, 2'b10, 32'h0000_0104, 1'b0, 32'h0, "R2 word read p32");
    do_req(2, 2'b00, 32'h0000_0106, 1'b0, 32'h0, "R2 byte read p32");
    do_req(2, 2'b01, 32'h0000_010A, 1'b1, 32'hAABB_CCDD, "R7 half write p32");
    do_req(2, 2'b00, 32'h0000_0111, 1'b1, 32'h0102_0304, "R7 byte write p32");
    // R1 code 11 behaves as 32-bit
    do_req(3, 2'b10, 32'h0000_0200, 1'b0, 32'h0, "R1 code11 read");
    do_req(3, 2'b11, 32'h0000_0204, 1'b1, 32'h5566_7788, "R1 size11 write");
    // R3 16-bit port
    do_req(1, 2'b10, 32'h0000_0300, 1'b1, 32'hCAFE_F00D, "R3 word write p16");
    do_req(1, 2'b10, 32'h0000_0308, 1'b0, 32'h0, "R3 word read p16");
    do_req(1, 2'b00, 32'h0000_0313, 1'b1, 32'h1020_3040, "R7 byte write p16");
    do_req(1, 2'b01, 32'h0000_0316, 1'b0, 32'h0, "R5 half read p16");
    // R4 8-bit port
    do_req(0, 2'b10, 32'h0000_0400, 1'b1, 32'h8899_AABB, "R4 word write p8");
    do_req(0, 2'b10, 32'h0000_0404, 1'b0, 32'h0, "R4 word read p8");
    do_req(0, 2'b01, 32'h0000_040A, 1'b0, 32'h0, "R5 half read p8");
    do_req(0, 2'b01, 32'h0000_040C, 1'b1, 32'h7766_5544, "R5 half write p8");
    do_req(0, 2'b00, 32'h0000_0412, 1'b0, 32'h0, "R5 byte read p8");
    // R10 rounding down of unaligned addresses
    do_req(1, 2'b10, 32'h0000_0506, 1'b0, 32'h0, "R10 word read p16");
    do_req(2, 2'b01, 32'h0000_0503, 1'b0, 32'h0, "R10 half read p32");
    do_req(0, 2'b10, 32'h0000_050B, 1'b1, 32'h0A0B_0C0D, "R10 word write p8");
    // R12 write completion data checked through rsp queue (expected zero)
    do_req(1, 2'b01, 32'h0000_0602, 1'b1, 32'h9999_1234, "R12 half write p16");

    while (qr_data.size() != 0 || qb_addr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    // R9 stray done while idle
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!rsp_valid && !bus_start && req_ready, "R9 stray done ignored",
          {29'h0, rsp_valid, bus_start, req_ready}, 32'h1);
      @(negedge clk);
    end
    do_req(0, 2'b10, 32'h0000_0700, 1'b0, 32'h0, "R9 read after stray done");
    while (qr_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule